// File: doc/BRIEF.md
# ACPI Embedded Controller Host Port Engine

This block is the host-side engine of an embedded controller's small byte-addressed configuration space. A host sends bytes tagged either as a command or as data. The engine runs the multi-byte transactions those bytes form: read, write, burst on, burst off and event query. It reports its progress in a status byte and returns result bytes on a separate result stream.

The space holds a version byte, a test byte with a complement byte that follows it, a block of writable configuration bytes, and a read-only window onto a larger shared memory map. The controller firmware updates that map through a plain update port. While burst mode is on, updates flagged as part of a multi-byte value are parked in a shadow copy. They are applied together when burst ends, so a host reading a multi-byte value never sees half of an update. The engine also keeps a 64-bit pending-event register and answers queries by retiring the lowest pending event.

Host bytes enter through a valid/ready pair. `host_ready` drops for exactly one cycle after each accepted byte while that byte is executed, and a byte is taken only in a cycle where valid and ready are both high. Results leave through a valid/ready pair. `res_valid` stays high with `res_byte` held until `res_ready` is seen. A newer result replaces one that was never taken. The map update port has no back-pressure, because every update is absorbed in the cycle it arrives.

Top module: `acpi_ec_port`

## Requirements
- R1: After reset the status byte is 0x00, `host_ready` is 1, `res_valid` is 0, the test byte reads 0x00 and its complement reads 0xFF.
- R2: A read is command byte 0x80 followed by one data byte holding the address. The result byte then appears on the result stream. Address 0x00 always returns 2.
- R3: A write is command byte 0x81, then an address data byte, then a value data byte. Addresses 0x03 to 0x13 are writable configuration bytes that read back the last value written (reset 0x00).
- R4: Writing value v to address 0x01 stores v there and sets address 0x02 to 0xFF minus v. Host writes to address 0x02 are dropped.
- R5: Host addresses 0x20 to 0xFF read map offsets 0x00 to 0xDF. Host writes to them are dropped. A map update outside burst mode is visible to the next host read.
- R6: Addresses 0x04 is writable, but addresses 0x14 to 0x1F are unimplemented: reads return 0xFF and writes are dropped.
- R7: Status bit 2 (processing) is 1 and `host_ready` is 0 in the single cycle after each accepted host byte. Status bit 3 is 1 when the last accepted host byte was a command and 0 when it was data. Status bit 0 mirrors `res_valid`, and bits 1, 6 and 7 read 0.
- R8: Command 0x84 clears the lowest-numbered pending event bit and returns its index plus one (bit 0 gives 1, bit 63 gives 64). It returns 0 when nothing is pending.
- R9: Status bit 5 is the OR of all pending events. It reflects a set or a query-driven clear in the cycle after that change.
- R10: Command 0x82 sets status bit 4 (burst). While burst is on, a map update flagged multi-byte is held in a shadow copy and is not visible, while an unflagged update applies at once. Command 0x83 clears bit 4 and applies all held updates in one cycle. An update arriving in that same cycle goes straight to the map and wins over a held value for that offset.
- R11: `res_valid` with `res_byte` stays stable until `res_ready` is high at a clock edge.
- R12: When an event set arrives in the same cycle that a query clears a bit, every newly set bit is pending afterwards, including the bit the query cleared.
- R13: Unknown command codes, and data bytes outside a read or write sequence, change no stored byte and produce no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_valid | input | 1 | Host byte offered |
| host_ready | output | 1 | Engine can take a host byte |
| host_is_cmd | input | 1 | 1 marks the byte as a command, 0 as data |
| host_byte | input | 8 | Host byte value |
| res_valid | output | 1 | Result byte available |
| res_ready | input | 1 | Host takes the result byte |
| res_byte | output | 8 | Result of a read or query |
| status | output | 8 | Status byte (bits 0, 2, 3, 4 and 5 are used) |
| evt_set | input | NUM_EVT | One-cycle pulses that raise pending events |
| map_up_valid | input | 1 | Firmware map update strobe |
| map_up_multi | input | 1 | Update belongs to a multi-byte value |
| map_up_addr | input | MIDX_W | Map offset to update |
| map_up_data | input | 8 | Map update value |

## Verification
Two pairs of functions can land in the same clock edge. The first pair is a query retiring an event while firmware raises events. The bench pulses `evt_set` during the processing cycle of a 0x84 command, including the very bit being retired. It then checks the returned code and the codes of the later queries against a model in which sets win over the clear. The second pair is burst release and a map update. The bench drives a multi-byte update during the processing cycle of 0x83, to an offset that already holds a parked value, and expects the directly written value on the following read.

// File: rtl/acpi_ec_pkg.sv
package acpi_ec_pkg;
  localparam logic [7:0] CMD_READ    = 8'h80;
  localparam logic [7:0] CMD_WRITE   = 8'h81;
  localparam logic [7:0] CMD_BURST_ON  = 8'h82;
  localparam logic [7:0] CMD_BURST_OFF = 8'h83;
  localparam logic [7:0] CMD_QUERY   = 8'h84;

  localparam logic [7:0] ADDR_VERSION = 8'h00;
  localparam logic [7:0] ADDR_TEST    = 8'h01;
  localparam logic [7:0] ADDR_COMP    = 8'h02;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_RD_ADDR,
    PH_WR_ADDR,
    PH_WR_VAL
  } phase_e;

  typedef enum logic [2:0] {
    OP_NONE,
    OP_READ,
    OP_WRITE,
    OP_QUERY,
    OP_BURST_ON,
    OP_BURST_OFF
  } op_e;
endpackage

// File: rtl/ec_host_seq.sv
module ec_host_seq
  import acpi_ec_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hw_valid,
  output logic       hw_ready,
  input  logic       hw_is_cmd,
  input  logic [7:0] hw_byte,
  output logic       rsp_valid,
  input  logic       rsp_ready,
  output logic [7:0] rsp_byte,
  output logic [7:0] acc_addr,
  output logic [7:0] acc_wdata,
  output logic       acc_we,
  input  logic [7:0] acc_rdata,
  output logic       qry_go,
  input  logic [7:0] qry_code,
  output logic       burst,
  output logic       burst_release,
  output logic       busy,
  output logic       last_cmd
);
  phase_e     phase_q;
  op_e        op_q;
  logic       busy_q, last_cmd_q, burst_q, rsp_valid_q;
  logic [7:0] addr_q, wdata_q, rsp_q;
  logic       accept;

  assign accept = hw_valid && !busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q     <= PH_IDLE;
      op_q        <= OP_NONE;
      busy_q      <= 1'b0;
      last_cmd_q  <= 1'b0;
      burst_q     <= 1'b0;
      rsp_valid_q <= 1'b0;
      addr_q      <= '0;
      wdata_q     <= '0;
      rsp_q       <= '0;
    end else begin
      if (accept) begin
        busy_q  <= 1'b1;
        op_q    <= OP_NONE;
        phase_q <= PH_IDLE;
        if (hw_is_cmd) begin
          last_cmd_q <= 1'b1;
          case (hw_byte)
            CMD_READ:      phase_q <= PH_RD_ADDR;
            CMD_WRITE:     phase_q <= PH_WR_ADDR;
            CMD_BURST_ON:  op_q    <= OP_BURST_ON;
            CMD_BURST_OFF: op_q    <= OP_BURST_OFF;
            CMD_QUERY:     op_q    <= OP_QUERY;
            default: ;
          endcase
        end else begin
          last_cmd_q <= 1'b0;
          case (phase_q)
            PH_RD_ADDR: begin addr_q <= hw_byte; op_q <= OP_READ; end
            PH_WR_ADDR: begin addr_q <= hw_byte; phase_q <= PH_WR_VAL; end
            PH_WR_VAL:  begin wdata_q <= hw_byte; op_q <= OP_WRITE; end
            default: ;
          endcase
        end
      end else if (busy_q) begin
        busy_q <= 1'b0;
        op_q   <= OP_NONE;
        case (op_q)
          OP_BURST_ON:  burst_q <= 1'b1;
          OP_BURST_OFF: burst_q <= 1'b0;
          default: ;
        endcase
      end

      if (busy_q && (op_q == OP_READ || op_q == OP_QUERY)) begin
        rsp_valid_q <= 1'b1;
        rsp_q       <= (op_q == OP_READ) ? acc_rdata : qry_code;
      end else if (rsp_ready) begin
        rsp_valid_q <= 1'b0;
      end
    end
  end

  assign hw_ready      = !busy_q;
  assign rsp_valid     = rsp_valid_q;
  assign rsp_byte      = rsp_q;
  assign acc_addr      = addr_q;
  assign acc_wdata     = wdata_q;
  assign acc_we        = busy_q && (op_q == OP_WRITE);
  assign qry_go        = busy_q && (op_q == OP_QUERY);
  assign burst         = burst_q;
  assign burst_release = busy_q && (op_q == OP_BURST_OFF) && burst_q;
  assign busy          = busy_q;
  assign last_cmd      = last_cmd_q;

  // R7
  proc_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_valid && hw_ready) |=> busy);

  // R7
  one_cycle_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> !busy);

  // R11
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready && !busy) |=> (rsp_valid && $stable(rsp_byte)));
endmodule

// File: rtl/ec_acpi_space.sv
module ec_acpi_space
  import acpi_ec_pkg::*;
#(
  parameter int VERSION   = 2,
  parameter int CFG_FIRST = 3,
  parameter int CFG_COUNT = 17,
  parameter int WIN_BASE  = 32,
  parameter int MAP_BYTES = 224,
  localparam int MIDX_W   = $clog2(MAP_BYTES),
  localparam int CIDX_W   = $clog2(CFG_COUNT)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        addr,
  output logic [7:0]        rd_data,
  input  logic              we,
  input  logic [7:0]        wr_data,
  input  logic              up_valid,
  input  logic              up_multi,
  input  logic [MIDX_W-1:0] up_addr,
  input  logic [7:0]        up_data,
  input  logic              burst,
  input  logic              burst_release
);
  localparam logic [7:0]    VER_B  = 8'(VERSION);
  localparam logic [7:0]    CFG_LO = 8'(CFG_FIRST);
  localparam logic [8:0]    CFG_HI = 9'(CFG_FIRST + CFG_COUNT);
  localparam logic [7:0]    WIN_LO = 8'(WIN_BASE);
  localparam logic [8:0]    WIN_HI = 9'(WIN_BASE + MAP_BYTES);
  localparam logic [MIDX_W:0] MAP_N = (MIDX_W+1)'(MAP_BYTES);

  logic [7:0]                   test_q, comp_q;
  logic [CFG_COUNT-1:0][7:0]    cfg_q;
  logic [MAP_BYTES-1:0][7:0]    map_q, shadow_q;
  logic [MAP_BYTES-1:0]         dirty_q;
  logic                         in_cfg, in_win, hold, up_ok;
  logic [CIDX_W-1:0]            cfg_idx;
  logic [MIDX_W-1:0]            win_idx;

  assign in_cfg  = (addr >= CFG_LO) && ({1'b0, addr} < CFG_HI);
  assign in_win  = (addr >= WIN_LO) && ({1'b0, addr} < WIN_HI);
  assign cfg_idx = CIDX_W'(addr - CFG_LO);
  assign win_idx = MIDX_W'(addr - WIN_LO);
  assign hold    = burst && !burst_release;
  assign up_ok   = up_valid && ({1'b0, up_addr} < MAP_N);

  always_comb begin
    rd_data = 8'hFF;
    if (addr == ADDR_VERSION)   rd_data = VER_B;
    else if (addr == ADDR_TEST) rd_data = test_q;
    else if (addr == ADDR_COMP) rd_data = comp_q;
    else if (in_cfg)            rd_data = cfg_q[cfg_idx];
    else if (in_win)            rd_data = map_q[win_idx];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      test_q   <= 8'h00;
      comp_q   <= 8'hFF;
      cfg_q    <= '0;
      map_q    <= '0;
      shadow_q <= '0;
      dirty_q  <= '0;
    end else begin
      if (we) begin
        if (addr == ADDR_TEST) begin
          test_q <= wr_data;
          comp_q <= ~wr_data;
        end else if (in_cfg) begin
          cfg_q[cfg_idx] <= wr_data;
        end
      end
      if (burst_release) begin
        for (int i = 0; i < MAP_BYTES; i++)
          if (dirty_q[i]) map_q[i] <= shadow_q[i];
        dirty_q <= '0;
      end
      if (up_ok) begin
        if (hold && up_multi) begin
          shadow_q[up_addr] <= up_data;
          dirty_q[up_addr]  <= 1'b1;
        end else begin
          map_q[up_addr] <= up_data;
        end
      end
    end
  end

  // R4
  test_comp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_TEST) |=> (comp_q == ~$past(wr_data)));

  // R4
  comp_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == ADDR_COMP) |=> $stable(comp_q));

  // R5
  win_ro_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (we && in_win && !up_valid && !burst_release) |=> $stable(map_q));

  // R10
  burst_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && !(up_valid && !up_multi)) |=> $stable(map_q));
endmodule

// File: rtl/ec_event_query.sv
module ec_event_query #(
  parameter int NUM_EVT = 64,
  parameter int CODE_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_EVT-1:0] evt_set,
  input  logic               qry_go,
  output logic [CODE_W-1:0]  qry_code,
  output logic               sci_pending
);
  logic [NUM_EVT-1:0] pend_q, low_oh;
  logic               found;

  always_comb begin
    low_oh   = '0;
    qry_code = '0;
    found    = 1'b0;
    for (int i = 0; i < NUM_EVT; i++) begin
      if (!found && pend_q[i]) begin
        found     = 1'b1;
        low_oh[i] = 1'b1;
        qry_code  = CODE_W'(i + 1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= '0;
    else        pend_q <= (pend_q & ~(qry_go ? low_oh : '0)) | evt_set;
  end

  assign sci_pending = |pend_q;

  // R8
  query_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (qry_go && (|pend_q) && evt_set == '0)
      |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));

  // R12
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt_set) |=> ((pend_q & $past(evt_set)) == $past(evt_set)));
endmodule

// File: rtl/acpi_ec_port.sv
module acpi_ec_port #(
  parameter int NUM_EVT   = 64,
  parameter int VERSION   = 2,
  parameter int CFG_FIRST = 3,
  parameter int CFG_COUNT = 17,
  parameter int WIN_BASE  = 32,
  parameter int MAP_BYTES = 224,
  localparam int MIDX_W   = $clog2(MAP_BYTES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               host_valid,
  output logic               host_ready,
  input  logic               host_is_cmd,
  input  logic [7:0]         host_byte,
  output logic               res_valid,
  input  logic               res_ready,
  output logic [7:0]         res_byte,
  output logic [7:0]         status,
  input  logic [NUM_EVT-1:0] evt_set,
  input  logic               map_up_valid,
  input  logic               map_up_multi,
  input  logic [MIDX_W-1:0]  map_up_addr,
  input  logic [7:0]         map_up_data
);
  logic [7:0] acc_addr, acc_wdata, acc_rdata, qry_code;
  logic       acc_we, qry_go, burst, burst_release, busy, last_cmd, sci;

  ec_host_seq u_seq (
    .clk(clk), .rst_n(rst_n),
    .hw_valid(host_valid), .hw_ready(host_ready),
    .hw_is_cmd(host_is_cmd), .hw_byte(host_byte),
    .rsp_valid(res_valid), .rsp_ready(res_ready), .rsp_byte(res_byte),
    .acc_addr(acc_addr), .acc_wdata(acc_wdata), .acc_we(acc_we),
    .acc_rdata(acc_rdata), .qry_go(qry_go), .qry_code(qry_code),
    .burst(burst), .burst_release(burst_release),
    .busy(busy), .last_cmd(last_cmd)
  );

  ec_acpi_space #(
    .VERSION(VERSION), .CFG_FIRST(CFG_FIRST), .CFG_COUNT(CFG_COUNT),
    .WIN_BASE(WIN_BASE), .MAP_BYTES(MAP_BYTES)
  ) u_space (
    .clk(clk), .rst_n(rst_n),
    .addr(acc_addr), .rd_data(acc_rdata),
    .we(acc_we), .wr_data(acc_wdata),
    .up_valid(map_up_valid), .up_multi(map_up_multi),
    .up_addr(map_up_addr), .up_data(map_up_data),
    .burst(burst), .burst_release(burst_release)
  );

  ec_event_query #(.NUM_EVT(NUM_EVT), .CODE_W(8)) u_evt (
    .clk(clk), .rst_n(rst_n),
    .evt_set(evt_set), .qry_go(qry_go),
    .qry_code(qry_code), .sci_pending(sci)
  );

  assign status = {2'b00, sci, burst, last_cmd, busy, 1'b0, res_valid};
endmodule

// File: tb/tb_acpi_ec_port.sv
`timescale 1ns/1ps
module tb_acpi_ec_port;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_valid = 1'b0, host_is_cmd = 1'b0, res_ready = 1'b0;
  logic [7:0]  host_byte = '0;
  logic        host_ready, res_valid;
  logic [7:0]  res_byte, status;
  logic [63:0] evt_set = '0;
  logic        map_up_valid = 1'b0, map_up_multi = 1'b0;
  logic [7:0]  map_up_addr = '0, map_up_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0]  m_test = 8'h00, m_comp = 8'hFF;
  logic [7:0]  m_cfg [17];
  logic [7:0]  m_map [224];
  logic [63:0] m_pend = '0;

  always #4 clk = ~clk;

  acpi_ec_port dut (
    .clk(clk), .rst_n(rst_n),
    .host_valid(host_valid), .host_ready(host_ready),
    .host_is_cmd(host_is_cmd), .host_byte(host_byte),
    .res_valid(res_valid), .res_ready(res_ready), .res_byte(res_byte),
    .status(status), .evt_set(evt_set),
    .map_up_valid(map_up_valid), .map_up_multi(map_up_multi),
    .map_up_addr(map_up_addr), .map_up_data(map_up_data)
  );

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    if (a == 8'h00) return 8'd2;
    if (a == 8'h01) return m_test;
    if (a == 8'h02) return m_comp;
    if (a >= 8'h03 && a <= 8'h13) return m_cfg[a - 8'h03];
    if (a >= 8'h20) return m_map[a - 8'h20];
    return 8'hFF;
  endfunction

  function automatic void model_write(input logic [7:0] a, input logic [7:0] v);
    if (a == 8'h01) begin m_test = v; m_comp = 8'hFF - v; end
    else if (a >= 8'h03 && a <= 8'h13) m_cfg[a - 8'h03] = v;
  endfunction

  function automatic logic [7:0] exp_query();
    for (int i = 0; i < 64; i++) if (m_pend[i]) return 8'(i + 1);
    return 8'd0;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input bit is_cmd, input logic [7:0] b);
    @(negedge clk);
    while (!host_ready) @(negedge clk);
    host_valid = 1'b1; host_is_cmd = is_cmd; host_byte = b;
    @(negedge clk);
    host_valid = 1'b0;
  endtask

  task automatic get_rsp(output logic [7:0] b);
    int n = 0;
    while (!res_valid && n < 20) begin @(negedge clk); n++; end
    chk(res_valid, "R11 result timeout", 0, 1);
    b = res_byte;
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
  endtask

  task automatic host_read(input logic [7:0] a, output logic [7:0] b);
    put(1'b1, 8'h80);
    put(1'b0, a);
    get_rsp(b);
  endtask

  task automatic host_write(input logic [7:0] a, input logic [7:0] v);
    put(1'b1, 8'h81);
    put(1'b0, a);
    put(1'b0, v);
    model_write(a, v);
  endtask

  task automatic map_up(input logic [7:0] off, input logic [7:0] v, input bit multi);
    @(negedge clk);
    map_up_valid = 1'b1; map_up_multi = multi; map_up_addr = off; map_up_data = v;
    @(negedge clk);
    map_up_valid = 1'b0;
  endtask

  task automatic evt_pulse(input logic [63:0] bits);
    @(negedge clk);
    evt_set = bits;
    @(negedge clk);
    evt_set = '0;
    m_pend = m_pend | bits;
  endtask

  task automatic query_chk(input string req);
    logic [7:0] got, exp;
    exp = exp_query();
    put(1'b1, 8'h84);
    get_rsp(got);
    chk(got == exp, req, got, exp);
    if (exp != 0) m_pend[exp - 1] = 1'b0;
  endtask

  task automatic read_chk(input logic [7:0] a, input string req);
    logic [7:0] got;
    host_read(a, got);
    chk(got == exp_read(a), req, got, exp_read(a));
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [7:0] got, held;
    for (int i = 0; i < 17; i++) m_cfg[i] = 8'h00;
    for (int i = 0; i < 224; i++) m_map[i] = 8'h00;
    void'($urandom(32'd20240611));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(status == 8'h00, "R1 status", status, 0);
    chk(host_ready == 1'b1 && res_valid == 1'b0, "R1 handshake", {host_ready, res_valid}, 2);
    read_chk(8'h01, "R1 test byte");
    read_chk(8'h02, "R1 complement byte");

    // R2 version; R7 flags per byte
    put(1'b1, 8'h80);
    chk(status[2] == 1'b1 && host_ready == 1'b0, "R7 processing", status, 8'h0C);
    chk(status[3] == 1'b1, "R7 last cmd", status[3], 1);
    put(1'b0, 8'h00);
    chk(status[3] == 1'b0 && status[2] == 1'b1, "R7 last data", status, 8'h04);
    get_rsp(got);
    chk(got == 8'd2, "R2 version", got, 2);
    @(negedge clk);
    chk(status[2] == 1'b0 && status[0] == 1'b0, "R7 idle", status, 0);

    // R4 test/complement
    host_write(8'h01, 8'h35);
    read_chk(8'h02, "R4 complement");
    read_chk(8'h01, "R4 test");
    host_write(8'h02, 8'h11);
    read_chk(8'h02, "R4 complement write dropped");

    // R3 configuration bytes at the edges
    host_write(8'h03, 8'h64);
    host_write(8'h13, 8'h7F);
    read_chk(8'h03, "R3 first cfg");
    read_chk(8'h13, "R3 last cfg");

    // R6 unimplemented
    host_write(8'h15, 8'h12);
    read_chk(8'h15, "R6 unimplemented");
    read_chk(8'h1F, "R6 unimplemented top");

    // R5 window
    map_up(8'd0, 8'h11, 1'b0);   m_map[0] = 8'h11;
    map_up(8'd223, 8'hEE, 1'b1); m_map[223] = 8'hEE;
    read_chk(8'h20, "R5 window base");
    read_chk(8'hFF, "R5 window top");
    host_write(8'h20, 8'h99);
    read_chk(8'h20, "R5 window write dropped");

    // R13 unknown command and stray data
    put(1'b1, 8'h55);
    put(1'b0, 8'h03);
    put(1'b0, 8'hAB);
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b0, "R13 no result", res_valid, 0);
    read_chk(8'h03, "R13 cfg untouched");

    // R11 back-pressure
    put(1'b1, 8'h80);
    put(1'b0, 8'h03);
    @(negedge clk);
    held = res_byte;
    repeat (3) @(negedge clk);
    chk(res_valid == 1'b1 && res_byte == held && held == 8'h64, "R11 hold", res_byte, 8'h64);
    get_rsp(got);
    @(negedge clk);
    chk(res_valid == 1'b0, "R11 consumed", res_valid, 0);

    // R8 / R9 queries
    query_chk("R8 empty query");
    evt_pulse(64'h8000_0000_0000_0021);
    chk(status[5] == 1'b1, "R9 sci set", status[5], 1);
    query_chk("R8 bit0");
    chk(status[5] == 1'b1, "R9 sci still", status[5], 1);
    query_chk("R8 bit5");
    query_chk("R8 bit63");
    chk(status[5] == 1'b0, "R9 sci cleared", status[5], 0);
    query_chk("R8 drained");

    // R12 set during query clear of the same bit
    evt_pulse(64'h4);
    put(1'b1, 8'h84);
    evt_set = 64'h6;
    @(negedge clk);
    evt_set = '0;
    get_rsp(got);
    chk(got == 8'd3, "R12 code", got, 3);
    m_pend = 64'h6;
    query_chk("R12 bit1 kept");
    query_chk("R12 bit2 kept");
    query_chk("R12 drained");

    // R10 burst
    map_up(8'd4, 8'h40, 1'b1); m_map[4] = 8'h40;
    put(1'b1, 8'h82);
    @(negedge clk);
    chk(status[4] == 1'b1, "R10 burst on", status[4], 1);
    map_up(8'd4, 8'h41, 1'b1);
    map_up(8'd6, 8'h60, 1'b1);
    map_up(8'd5, 8'h50, 1'b0); m_map[5] = 8'h50;
    read_chk(8'h24, "R10 held update");
    read_chk(8'h25, "R10 single-byte update");
    read_chk(8'h26, "R10 held second");
    put(1'b1, 8'h83);
    map_up_valid = 1'b1; map_up_multi = 1'b1; map_up_addr = 8'd6; map_up_data = 8'h66;
    @(negedge clk);
    map_up_valid = 1'b0;
    m_map[4] = 8'h41; m_map[6] = 8'h66;
    chk(status[4] == 1'b0, "R10 burst off", status[4], 0);
    read_chk(8'h24, "R10 released");
    read_chk(8'h26, "R10 release-cycle update wins");

    // random mix
    for (int it = 0; it < 200; it++) begin
      int sel;
      logic [7:0] a, v;
      sel = int'($urandom % 4);
      a = 8'($urandom);
      v = 8'($urandom);
      case (sel)
        0: host_write(a, v);
        1: read_chk(a, "R2 random read");
        2: begin
          logic [7:0] off;
          off = 8'($urandom % 224);
          map_up(off, v, 1'($urandom));
          m_map[off] = v;
        end
        default: begin
          if ($urandom % 2 == 0) evt_pulse(64'(1) << ($urandom % 64));
          query_chk("R8 random query");
        end
      endcase
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule